// File: doc/BRIEF.md
# Microframe Frame Index Counter

This block is the frame index register of a host controller. A microframe tick
strobe arrives every 125 µs. While the controller is running, each tick moves a
14-bit index up by one. Bits 3 and above of the index pick the entry of a
periodic frame list whose length is programmable: 1024, 512 or 256 entries. The
upper bound of that entry select follows the list size. When the index carries
out of the entry select, the block gives the status logic a single-cycle
rollover pulse.

Software can load the index only while the controller is halted, and only with
a full 32-bit write. A write with some byte lanes missing is dropped. A write
made while the controller runs is also dropped.

A two-state machine tracks the controller's run flag. `ST_HALTED` moves to
`ST_RUNNING` through transition GO, taken at a clock edge where `run_i` is high.
`ST_RUNNING` moves back to `ST_HALTED` through transition STOP, taken at an edge
where `run_i` is low. The state on the clock edge decides what that edge does.
A tick counts only when the state is `ST_RUNNING`. A write loads only when the
state is `ST_HALTED`.

Top module: `mfidx_counter`

## Requirements
- R1: An active-low reset (`rst_n` = 0) forces the following, regardless of the clock: `index_q` = 0, `rollover_o` = 0, state `ST_HALTED`.
- R2: At a clock edge where the state is `ST_RUNNING` and `uframe_tick_i` = 1, the index increases by exactly one. The state changes at each edge to match `run_i` (1 = running), so a tick at the edge where GO is taken does not count.
- R3: While the state is `ST_HALTED`, ticks do not change the index.
- R4: In `ST_HALTED`, a write with `wr_en_i` = 1 and `wr_be_i` = 4'b1111 loads `wr_data_i[13:0]` into the index at that edge.
- R5: A write with any `wr_be_i` value other than 4'b1111 is ignored.
- R6: A write made while the state is `ST_RUNNING` is dropped, and a tick at the same edge still advances the index.
- R7: `index_q[31:14]` is always zero. The index wraps from 0x3FFF to 0x0000.
- R8: `entry_sel_o[9:0]` equals `index_q[12:3]` with every bit above the list's top bit N forced to zero. Code `list_size_i` = 2'b00 gives N = 12 (1024 entries), 2'b01 gives N = 11 (512 entries), 2'b10 gives N = 10 (256 entries).
- R9: The reserved size code 2'b11 behaves exactly like 2'b00: no masking, with rollover at bit 12.
- R10: `rollover_o` is high for exactly one cycle, the cycle after an advancing edge at which `index[N:0]` was all ones. That is the cycle in which the new index shows. No other change to the index raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uframe_tick_i | input | 1 | One-cycle strobe per 125 µs microframe |
| run_i | input | 1 | Controller run flag (1 = running, 0 = halted) |
| list_size_i | input | 2 | Frame list size code |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 4 | Byte enables of the write |
| wr_data_i | input | 32 | Write data |
| index_q | output | 32 | Current index, upper 18 bits zero |
| entry_sel_o | output | 10 | Frame list entry select |
| rollover_o | output | 1 | One-cycle frame list rollover pulse |

## Verification
A state machine stuck in the wrong state shows at the ports within one cycle of the mismatch. Either a tick fails to move `index_q`, or a halted-time write fails to load. A wrong size decode affects `entry_sel_o` at once, and it also moves the rollover pulse by as many as thousands of microframes. For that reason, the bench sets up the index just below each carry boundary and samples `rollover_o` in the single cycle after the advancing edge. The bench checks `index_q` and `entry_sel_o` after every vector, so a dropped or accepted write shows at the very next sample.

// File: rtl/mfidx_pkg.sv
package mfidx_pkg;

    typedef enum logic [0:0] {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        LS_1024 = 2'b00,
        LS_512  = 2'b01,
        LS_256  = 2'b10,
        LS_RSVD = 2'b11
    } list_size_e;

    localparam int unsigned TOP_1024 = 12;
    localparam int unsigned TOP_512  = 11;
    localparam int unsigned TOP_256  = 10;

    // Highest index bit that belongs to the entry select for a size code.
    function automatic int unsigned list_top_bit(input logic [1:0] code);
        unique case (list_size_e'(code))
            LS_512:  return TOP_512;
            LS_256:  return TOP_256;
            default: return TOP_1024;
        endcase
    endfunction

endpackage

// File: rtl/mfidx_fsm.sv
module mfidx_fsm
    import mfidx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic full_wr_i,
    output logic running_o,
    output logic adv_o,
    output logic load_o
);
    run_state_e state_q;
    run_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:  if (run_i)  state_d = ST_RUNNING;  // GO
            ST_RUNNING: if (!run_i) state_d = ST_HALTED;   // STOP
            default:    state_d = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        running_o = 1'b0;
        adv_o     = 1'b0;
        load_o    = 1'b0;
        unique case (state_q)
            ST_HALTED:  load_o = full_wr_i;
            ST_RUNNING: begin
                running_o = 1'b1;
                adv_o     = tick_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mfidx_count.sv
module mfidx_count #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [1:0]       size_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             roll_o
);
    import mfidx_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] low_mask;
    logic             carry_out;

    always_comb begin
        low_mask  = CNT_W'((32'd1 << (list_top_bit(size_i) + 32'd1)) - 32'd1);
        carry_out = ((cnt_q & low_mask) == low_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            roll_o <= 1'b0;
        end else begin
            roll_o <= adv_i & carry_out;
            if (load_i)     cnt_q <= load_val_i;
            else if (adv_i) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/mfidx_select.sv
module mfidx_select #(
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned SEL_LSB = 3,
    parameter int unsigned SEL_W   = 10
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [1:0]       size_i,
    output logic [SEL_W-1:0] sel_o
);
    import mfidx_pkg::*;

    int unsigned top;
    assign top = list_top_bit(size_i);

    for (genvar g = 0; g < SEL_W; g++) begin : g_bit
        assign sel_o[g] = cnt_i[SEL_LSB + g] & ((SEL_LSB + g) <= top);
    end
endmodule

// File: rtl/mfidx_counter.sv
module mfidx_counter #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned SEL_LSB = 3,
    parameter int unsigned SEL_MSB = 12,
    localparam int unsigned BE_W   = DATA_W / 8,
    localparam int unsigned SEL_W  = SEL_MSB - SEL_LSB + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uframe_tick_i,
    input  logic              run_i,
    input  logic [1:0]        list_size_i,
    input  logic              wr_en_i,
    input  logic [BE_W-1:0]   wr_be_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] index_q,
    output logic [SEL_W-1:0]  entry_sel_o,
    output logic              rollover_o
);
    logic             is_running;
    logic             adv;
    logic             load;
    logic             full_wr;
    logic [CNT_W-1:0] cnt;

    assign full_wr = wr_en_i & (&wr_be_i);

    mfidx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .tick_i    (uframe_tick_i),
        .full_wr_i (full_wr),
        .running_o (is_running),
        .adv_o     (adv),
        .load_o    (load)
    );

    mfidx_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .load_i     (load),
        .load_val_i (wr_data_i[CNT_W-1:0]),
        .size_i     (list_size_i),
        .cnt_o      (cnt),
        .roll_o     (rollover_o)
    );

    mfidx_select #(.CNT_W(CNT_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W)) u_select (
        .cnt_i  (cnt),
        .size_i (list_size_i),
        .sel_o  (entry_sel_o)
    );

    assign index_q = {{(DATA_W - CNT_W){1'b0}}, cnt};
endmodule

// File: rtl/mfidx_checker.sv
module mfidx_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 14,
    parameter int unsigned SEL_W  = 10,
    parameter int unsigned BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              running,
    input logic              wr_en,
    input logic [BE_W-1:0]   wr_be,
    input logic [1:0]        size,
    input logic [DATA_W-1:0] index_q,
    input logic [SEL_W-1:0]  entry_sel,
    input logic              rollover
);
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick) |=> index_q[CNT_W-1:0] == $past(index_q[CNT_W-1:0]) + CNT_W'(1));

    a_r3_hold_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(index_q));

    a_r5_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && wr_en && !(&wr_be)) |=> $stable(index_q));

    a_r6_run_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && !tick) |=> $stable(index_q));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        index_q[DATA_W-1:CNT_W] == '0);

    a_r8_top_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b01 || size == 2'b10) |-> entry_sel[SEL_W-1] == 1'b0);

    a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |-> $past(running && tick));

    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> !rollover);
endmodule

bind mfidx_counter mfidx_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .BE_W(BE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (uframe_tick_i),
    .running   (is_running),
    .wr_en     (wr_en_i),
    .wr_be     (wr_be_i),
    .size      (list_size_i),
    .index_q   (index_q),
    .entry_sel (entry_sel_o),
    .rollover  (rollover_o)
);

// File: tb/mfidx_counter_tb.sv
module mfidx_counter_tb;
    localparam int CLK_P = 10;
    localparam int NV    = 13;

    typedef struct packed {
        logic        run;
        logic        tick;
        logic        wr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [1:0]  code;
        logic [13:0] exp_idx;
        logic        exp_roll;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 4'hF, 32'h0000_07FE, 2'b10, 14'h07FE, 1'b0}, // R4 full write
        '{1'b0, 1'b0, 1'b1, 4'h3, 32'h0000_1234, 2'b10, 14'h07FE, 1'b0}, // R5 partial
        '{1'b0, 1'b1, 1'b0, 4'h0, 32'h0,         2'b10, 14'h07FE, 1'b0}, // R3 tick halted
        '{1'b1, 1'b1, 1'b0, 4'h0, 32'h0,         2'b10, 14'h07FE, 1'b0}, // R2 GO edge
        '{1'b1, 1'b1, 1'b0, 4'h0, 32'h0,         2'b10, 14'h07FF, 1'b0}, // R2
        '{1'b1, 1'b1, 1'b1, 4'hF, 32'h0,         2'b10, 14'h0800, 1'b1}, // R6 R10
        '{1'b1, 1'b1, 1'b0, 4'h0, 32'h0,         2'b10, 14'h0801, 1'b0}, // R10 drop
        '{1'b0, 1'b1, 1'b0, 4'h0, 32'h0,         2'b00, 14'h0802, 1'b0}, // R2 STOP edge
        '{1'b0, 1'b1, 1'b0, 4'h0, 32'h0,         2'b00, 14'h0802, 1'b0}, // R3
        '{1'b0, 1'b0, 1'b1, 4'hF, 32'hFFFF_FFFF, 2'b00, 14'h3FFF, 1'b0}, // R7 R4
        '{1'b1, 1'b0, 1'b0, 4'h0, 32'h0,         2'b00, 14'h3FFF, 1'b0}, // R2
        '{1'b1, 1'b1, 1'b0, 4'h0, 32'h0,         2'b00, 14'h0000, 1'b1}, // R7 wrap R10
        '{1'b1, 1'b1, 1'b0, 4'h0, 32'h0,         2'b01, 14'h0001, 1'b0}  // R8 code 01
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  code = 2'b00;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] index_q;
    logic [9:0]  entry_sel;
    logic        rollover;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P / 2) clk = ~clk;

    mfidx_counter u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .uframe_tick_i (tick),
        .run_i         (run),
        .list_size_i   (code),
        .wr_en_i       (wr_en),
        .wr_be_i       (wr_be),
        .wr_data_i     (wr_data),
        .index_q       (index_q),
        .entry_sel_o   (entry_sel),
        .rollover_o    (rollover)
    );

    function automatic logic [9:0] exp_sel(input logic [13:0] i, input logic [1:0] c);
        logic [9:0] m;
        m = (c == 2'b01) ? 10'h1FF : (c == 2'b10) ? 10'h0FF : 10'h3FF;
        return i[12:3] & m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input logic [13:0] ei, input logic er);
        chk("R2/R7 index_q", index_q, {18'b0, ei});
        chk("R8 entry_sel", {22'b0, entry_sel}, {22'b0, exp_sel(ei, code)});
        chk("R10 rollover", {31'b0, rollover}, {31'b0, er});
    endtask

    task automatic step(input logic r, input logic t, input logic w, input logic [3:0] b,
                        input logic [31:0] d, input logic [1:0] c);
        run = r; tick = t; wr_en = w; wr_be = b; wr_data = d; code = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk_all(14'h0, 1'b0); // R1 reset state
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            step(VECS[k].run, VECS[k].tick, VECS[k].wr, VECS[k].be, VECS[k].data, VECS[k].code);
            chk_all(VECS[k].exp_idx, VECS[k].exp_roll);
        end

        // R1: reset while running clears the index
        step(1'b1, 1'b1, 1'b0, 4'h0, 32'h0, 2'b00);
        rst_n = 1'b0;
        #1;
        chk("R1 index_q async clear", index_q, 32'h0);
        @(negedge clk);
        chk_all(14'h0, 1'b0);
        rst_n = 1'b1;

        // R9: reserved code acts as 1024 entries, no carry at bit 11
        step(1'b0, 1'b0, 1'b1, 4'hF, 32'h0000_0FFF, 2'b11);
        step(1'b1, 1'b0, 1'b0, 4'h0, 32'h0, 2'b11);
        step(1'b1, 1'b1, 1'b0, 4'h0, 32'h0, 2'b11);
        chk("R9 index_q", index_q, 32'h0000_1000);
        chk("R9 entry_sel unmasked", {22'b0, entry_sel}, 32'h200);
        chk("R9 no rollover", {31'b0, rollover}, 32'h0);

        // R8/R10: 512 entries carries at bit 11
        step(1'b0, 1'b0, 1'b0, 4'h0, 32'h0, 2'b01);
        step(1'b0, 1'b0, 1'b1, 4'hF, 32'h0000_0FFF, 2'b01);
        chk("R4 reload", index_q, 32'h0000_0FFF);
        step(1'b1, 1'b0, 1'b0, 4'h0, 32'h0, 2'b01);
        step(1'b1, 1'b1, 1'b0, 4'h0, 32'h0, 2'b01);
        chk_all(14'h1000, 1'b1);
        step(1'b1, 1'b0, 1'b0, 4'h0, 32'h0, 2'b01);
        chk_all(14'h1000, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule